// File: doc/BRIEF.md
# Facility Data Link Receive Byte Collector

This block assembles the serial maintenance-channel bits that a T1 framer pulls out of the line (the data-link bits in extended-superframe mode, or the signaling-frame bits in the older superframe mode) into bytes. Each extracted bit arrives with a one-cycle valid strobe. Cycles without the strobe carry nothing. After a whole byte has been gathered, the block presents it on a byte output, pulses a ready strobe and a buffer-full event, and then compares the byte with two programmable reference bytes.

When HDLC-style transmission is in use, the block can remove the zero that a sender inserts after five consecutive ones. That zero never reaches the byte. A zero that follows a longer run of ones is kept, because it is part of a flag or an abort. Separately, a run of eight ones on the link raises an abort event whether or not destuffing is enabled.

Top module: `fdl_rx_collector`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rx_byte` is 0 and `byte_rdy`, `full_evt`, `match_evt` and `abort_evt` are all 0.
- R2: A cycle with `bit_vld` low has no effect. The value on `bit_in` in that cycle is neither collected nor counted in a ones run, and it neither ends a ones run nor starts one.
- R3: Kept bits fill the byte least significant bit first. The first kept bit of a byte lands in `rx_byte[0]` and the eighth lands in `rx_byte[7]`.
- R4: When a byte is completed, `rx_byte` takes the new value and `byte_rdy` and `full_evt` are high together for exactly one cycle. That cycle is the one after the second rising edge counted from the edge that samples the byte's last kept bit. `rx_byte` holds its value until the next byte is completed.
- R5: `match_evt` pulses for one cycle, one cycle after `byte_rdy`, when the completed byte equals `match_a` or `match_b`. Otherwise it stays low.
- R6: With `destuff_en` high, a valid 0 that follows exactly five consecutive valid 1s is discarded. It does not advance the count toward a full byte, and it ends the ones run.
- R7: With `destuff_en` high, a valid 0 that follows six or more consecutive valid 1s is kept as data.
- R8: With `destuff_en` low, every valid bit is kept, including a 0 after five 1s.
- R9: `abort_evt` pulses for one cycle, one cycle after the edge that samples the eighth consecutive valid 1. Further 1s in the same run give no further pulse, and any valid 0 re-arms the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Extracted link bit |
| bit_vld | input | 1 | Qualifies `bit_in` for one cycle |
| destuff_en | input | 1 | Enables stuffed-zero removal |
| match_a | input | 8 | First reference byte |
| match_b | input | 8 | Second reference byte |
| rx_byte | output | 8 | Last completed byte |
| byte_rdy | output | 1 | One-cycle strobe when `rx_byte` is updated |
| full_evt | output | 1 | One-cycle buffer-full event |
| match_evt | output | 1 | One-cycle reference-match event |
| abort_evt | output | 1 | One-cycle abort event |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a stuffing run of five and an abort run of eight. With these values, a discarded zero, a kept zero after six ones and a repeated abort pulse can each be provoked in one or two bytes of directed stimulus. Between valid bits the bench drives the inverse value on `bit_in`. This way, every scenario also shows that unqualified cycles are ignored, including a gap full of zeros inside a ones run.

// File: rtl/fdlrx_pkg.sv
package fdlrx_pkg;
  localparam int DEF_BYTE_W    = 8;
  localparam int DEF_STUFF_RUN = 5;
  localparam int DEF_ABORT_RUN = 8;

  typedef struct packed {
    logic dat;
    logic vld;
  } kept_t;
endpackage

// File: rtl/fdlrx_destuff.sv
module fdlrx_destuff
  import fdlrx_pkg::*;
#(
  parameter int STUFF_RUN = DEF_STUFF_RUN,
  parameter int ABORT_RUN = DEF_ABORT_RUN
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_in,
  input  logic  bit_vld,
  input  logic  destuff_en,
  output kept_t kept_o,
  output logic  abort_o
);
  localparam int RUN_W = $clog2(ABORT_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(ABORT_RUN);
  localparam logic [RUN_W-1:0] RUN_STUF = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ABORT_RUN - 1);

  logic [RUN_W-1:0] run_q;

  // The run counter saturates at the abort length, so an abort fires once per run.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      kept_o  <= '0;
      abort_o <= 1'b0;
    end else begin
      kept_o.vld <= 1'b0;
      abort_o    <= 1'b0;
      if (bit_vld) begin
        if (bit_in) begin
          if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
          abort_o    <= (run_q == RUN_LAST);
          kept_o.dat <= 1'b1;
          kept_o.vld <= 1'b1;
        end else begin
          run_q      <= '0;
          kept_o.dat <= 1'b0;
          kept_o.vld <= !(destuff_en && run_q == RUN_STUF);
        end
      end
    end
  end

  AST_ABORT_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> $past(bit_vld && bit_in)); // R9
  AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !destuff_en) |=> kept_o.vld); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> (!kept_o.vld && !abort_o)); // R2
endmodule

// File: rtl/fdlrx_assemble.sv
module fdlrx_assemble
  import fdlrx_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  kept_t             kept_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              rdy_o
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_nxt;
  logic [CNT_W-1:0]  cnt_q;

  // New bits enter at the top, so the first bit ends in bit 0.
  always_comb sh_nxt = {kept_i.dat, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      byte_o <= '0;
      rdy_o  <= 1'b0;
    end else begin
      rdy_o <= 1'b0;
      if (kept_i.vld) begin
        sh_q <= sh_nxt;
        if (cnt_q == CNT_LAST) begin
          cnt_q  <= '0;
          byte_o <= sh_nxt;
          rdy_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_RDY_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
    rdy_o |-> $past(kept_i.vld)); // R4
  AST_RDY_SPACED: assert property (@(posedge clk) disable iff (rst)
    rdy_o |=> !rdy_o); // R4
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    !rdy_o |-> $stable(byte_o)); // R4
endmodule

// File: rtl/fdlrx_match.sv
module fdlrx_match #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rdy_i,
  input  logic [BYTE_W-1:0] pat_a,
  input  logic [BYTE_W-1:0] pat_b,
  output logic              match_o
);
  always_ff @(posedge clk) begin
    if (rst) match_o <= 1'b0;
    else     match_o <= rdy_i && ((byte_i == pat_a) || (byte_i == pat_b));
  end

  AST_MATCH_AFTER_RDY: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(rdy_i)); // R5
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o); // R5
endmodule

// File: rtl/fdl_rx_collector.sv
module fdl_rx_collector
  import fdlrx_pkg::*;
#(
  parameter int BYTE_W    = DEF_BYTE_W,
  parameter int STUFF_RUN = DEF_STUFF_RUN,
  parameter int ABORT_RUN = DEF_ABORT_RUN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic              destuff_en,
  input  logic [BYTE_W-1:0] match_a,
  input  logic [BYTE_W-1:0] match_b,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_rdy,
  output logic              full_evt,
  output logic              match_evt,
  output logic              abort_evt
);
  kept_t kept;
  logic  rdy;

  fdlrx_destuff #(.STUFF_RUN(STUFF_RUN), .ABORT_RUN(ABORT_RUN)) u_destuff (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .destuff_en(destuff_en), .kept_o(kept), .abort_o(abort_evt)
  );

  fdlrx_assemble #(.BYTE_W(BYTE_W)) u_assemble (
    .clk(clk), .rst(rst), .kept_i(kept), .byte_o(rx_byte), .rdy_o(rdy)
  );

  fdlrx_match #(.BYTE_W(BYTE_W)) u_match (
    .clk(clk), .rst(rst), .byte_i(rx_byte), .rdy_i(rdy),
    .pat_a(match_a), .pat_b(match_b), .match_o(match_evt)
  );

  assign byte_rdy = rdy;
  assign full_evt = rdy;

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> !abort_evt); // R9
endmodule

// File: tb/fdl_rx_collector_tb_top.sv
module fdl_rx_collector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0;
  logic       bit_vld = 1'b0;
  logic       destuff_en = 1'b0;
  logic [7:0] match_a = 8'h00;
  logic [7:0] match_b = 8'h00;
  logic [7:0] rx_byte;
  logic       byte_rdy, full_evt, match_evt, abort_evt;

  int checks = 0;
  int errors = 0;
  int n_rdy = 0, n_match = 0, n_abort = 0;

  always #2 clk = ~clk;

  fdl_rx_collector dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .destuff_en(destuff_en), .match_a(match_a), .match_b(match_b),
    .rx_byte(rx_byte), .byte_rdy(byte_rdy), .full_evt(full_evt),
    .match_evt(match_evt), .abort_evt(abort_evt)
  );

  always @(posedge clk) begin
    if (byte_rdy)  n_rdy++;
    if (match_evt) n_match++;
    if (abort_evt) n_abort++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0; bit_in = ~b;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(rx_byte == 8'h00 && !byte_rdy && !full_evt && !match_evt && !abort_evt,
        "R1 outputs in reset", {rx_byte, byte_rdy, full_evt, match_evt, abort_evt}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_byte == 8'h00 && !byte_rdy && !abort_evt, "R1 after reset", rx_byte, 0);
  endtask

  task automatic t_byte_timing();
    int r0;
    do_reset();
    destuff_en = 1'b0;
    r0 = n_rdy;
    send_byte(8'hA5);
    chk(!byte_rdy, "R4 not early", byte_rdy, 0);
    @(negedge clk);
    chk(byte_rdy && full_evt, "R4 rdy and full together", {byte_rdy, full_evt}, 3);
    chk(rx_byte == 8'hA5, "R3 LSB first order", rx_byte, 8'hA5);
    @(negedge clk);
    chk(!byte_rdy && !full_evt, "R4 one cycle pulse", {byte_rdy, full_evt}, 0);
    chk(n_rdy - r0 == 1, "R2 gaps ignored, one byte", n_rdy - r0, 1);
    send_bit(1'b0); send_bit(1'b1);
    settle();
    chk(rx_byte == 8'hA5, "R4 byte held mid-byte", rx_byte, 8'hA5);
  endtask

  task automatic t_match();
    int m0;
    do_reset();
    destuff_en = 1'b0;
    match_a = 8'h3C; match_b = 8'h81;
    m0 = n_match;
    send_byte(8'h3C);
    @(negedge clk);
    chk(!match_evt, "R5 match not with rdy", match_evt, 0);
    @(negedge clk);
    chk(match_evt, "R5 match on reference a", match_evt, 1);
    send_byte(8'h81);
    settle();
    chk(n_match - m0 == 2, "R5 match on reference b", n_match - m0, 2);
    send_byte(8'h55);
    settle();
    chk(rx_byte == 8'h55 && n_match - m0 == 2, "R5 no match", n_match - m0, 2);
  endtask

  task automatic t_stuffed();
    int r0;
    do_reset();
    destuff_en = 1'b1;
    r0 = n_rdy;
    repeat (5) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    settle();
    chk(n_rdy - r0 == 1, "R6 dropped zero not counted", n_rdy - r0, 1);
    chk(rx_byte == 8'h5F, "R6 stuffed zero removed", rx_byte, 8'h5F);
  endtask

  task automatic t_six_ones();
    do_reset();
    destuff_en = 1'b1;
    repeat (6) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    settle();
    chk(rx_byte == 8'hBF, "R7 zero after six ones kept", rx_byte, 8'hBF);
  endtask

  task automatic t_no_destuff();
    int r0;
    do_reset();
    destuff_en = 1'b0;
    r0 = n_rdy;
    repeat (5) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    settle();
    chk(n_rdy - r0 == 1 && rx_byte == 8'h5F, "R8 every bit kept", rx_byte, 8'h5F);
  endtask

  task automatic t_abort();
    int a0;
    do_reset();
    destuff_en = 1'b1;
    a0 = n_abort;
    repeat (7) send_bit(1'b1);
    chk(!abort_evt && n_abort == a0, "R9 no abort at seven", n_abort - a0, 0);
    send_bit(1'b1);
    chk(abort_evt, "R9 abort on eighth one", abort_evt, 1);
    repeat (2) send_bit(1'b1);
    settle();
    chk(n_abort - a0 == 1, "R9 single pulse per run", n_abort - a0, 1);
    send_bit(1'b0);
    repeat (8) send_bit(1'b1);
    settle();
    chk(n_abort - a0 == 2, "R9 rearmed after zero", n_abort - a0, 2);
  endtask

  task automatic t_gap_run();
    int a0;
    do_reset();
    destuff_en = 1'b1;
    a0 = n_abort;
    repeat (3) send_bit(1'b1);
    @(negedge clk); bit_in = 1'b0;
    repeat (5) @(negedge clk);
    repeat (2) send_bit(1'b1);
    send_bit(1'b0);
    repeat (3) send_bit(1'b1);
    settle();
    chk(rx_byte == 8'hFF, "R2 invalid zeros do not break run", rx_byte, 8'hFF);
    chk(n_abort == a0, "R6 dropped zero ends run", n_abort - a0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_byte_timing();
    t_match();
    t_stuffed();
    t_six_ones();
    t_no_destuff();
    t_abort();
    t_gap_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule